// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-up to a state where a memory controller can use it. After a synchronous reset it walks through a fixed list of steps. Each step either sets the device control pins (clock enable, on-die termination, device reset) or places a single command on a one-phase command port (strobes, address, bank). After each step it waits a set number of cycles before the next step. When the last wait has run out, it raises a done flag, and the controller can then take the port.

The memory generation is chosen when the design is built: single data rate, DDR, low-power DDR, DDR2 or DDR3. Each generation has its own step order. CAS latency, CAS write latency and phase count are parameters. The sequencer computes every mode-register word from them. The burst length is the phase count for single data rate and twice the phase count for the double-rate generations.

The strobes on the port are assertion bits: 1 means the device pin is driven active. Inverting them to active-low levels is left to the PHY. A DDR3 build is meant to be used with four phases, which gives a burst length of 8.

Top module: `sdram_init_seq`

## Requirements
- R1: Strobe patterns, written as {cs,ras,cas,we}, are: precharge-all 4'b1101, mode-register load 4'b1111, auto-refresh 4'b1110, ZQ calibration 4'b1001. Outside a command slot all four are 0 (NOP), and no strobe is ever set without cs.
- R2: Every precharge-all and every ZQ calibration drives address 0x400 (A10 set) with bank 0.
- R3: For SDR, DDR, LPDDR and DDR2 the step order and waits are as follows:
  - The pins step sets cke, odt and reset_n all to 1 and waits 20000 cycles.
  - Then precharge-all.
  - Then any extended loads (see R5 and R6).
  - Then the DLL-reset mode load, which waits 200 cycles.
  - Then precharge-all.
  - Then two auto-refreshes, each waiting 4 cycles.
  - Then the final mode load, which waits 200 cycles.
  - A step with wait W is followed by the next step exactly 1+W cycles after it.
- R4: For SDR, DDR, LPDDR and DDR2 the mode word is log2(BL) + 16*CL, with BL = phases (SDR) or 2*phases. DDR2 adds 0x400 (write recovery 2 at bit 9). The DLL-reset load adds 0x100. Both loads use bank 0.
- R5: DDR inserts one extended load (address 0) on bank 1 before the DLL-reset load. LPDDR does the same on bank 2.
- R6: DDR2 has these extra loads:
  - Before the DLL-reset load it inserts loads on bank 3, then bank 2, then bank 1, all with address 0.
  - After the final mode load it appends a bank-1 load of 0x380 (bits 9:7 all set), then a bank-1 load of 0.
  - All of these loads have zero wait.
- R7: DDR3 runs these steps in order:
  - Set odt and reset_n to 1 with cke at 0, then wait 50000 cycles.
  - Set cke to 1, then wait 10000 cycles.
  - Load bank 2, bank 3 (address 0), bank 1 and bank 0 with no wait between them, then wait 200 cycles after the bank-0 load.
  - ZQ calibration, then wait 200 cycles.
- R8: The DDR3 bank-0 word works as follows:
  - The CAS-latency code is 2*(CL-4) for CL 5..11 and 2*(CL-12)+1 for CL 12..14.
  - Code bit 0 goes to A2 and code bits 3:1 go to A6:A4.
  - A8 is set for DLL reset.
  - A11:A9 hold 3'b100 (write recovery 8).
- R9: The DDR3 bank-2 word is (CWL-5) at A5:A3 plus 2 at A10:A9. The bank-1 word is 0x006.
- R10: Each command lasts exactly one cycle. The control pins change only in a pins step, never in the same cycle as a command, and otherwise hold their last value.
- R11: Done goes high exactly 1+W cycles after the last step, where W is that step's wait. It then stays high with the port idle until reset.
- R12: While reset is held, all strobes, address, bank, cke, odt, reset_n and done are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_cs | output | 1 | Chip-select assertion |
| cmd_ras | output | 1 | Row-strobe assertion |
| cmd_cas | output | 1 | Column-strobe assertion |
| cmd_we | output | 1 | Write-enable assertion |
| cmd_addr | output | 14 | Command address |
| cmd_bank | output | 3 | Command bank address |
| pin_cke | output | 1 | Device clock enable |
| pin_odt | output | 1 | Device on-die termination |
| pin_reset_n | output | 1 | Device reset level (1 = released) |
| init_done | output | 1 | Sequence complete |

## Verification
The cases hardest to reach are those fixed at build time: the CAS-latency codes above 11, which switch to the odd code branch, and the generation-specific step orders. No input at run time can steer the block into them. The bench therefore builds six copies side by side:
- two DDR3 copies, at CL 6 and at CL 13;
- one copy of each of the other four generations, with differing phase counts.

All six run from one reset. The 50000-cycle waits are kept at full length, so the back-to-back zero-wait loads and the long gaps are both timed against expected 1+W spacing.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    localparam int ADDR_W = 14;
    localparam int BANK_W = 3;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        MEM_SDR   = 3'd0,
        MEM_DDR   = 3'd1,
        MEM_LPDDR = 3'd2,
        MEM_DDR2  = 3'd3,
        MEM_DDR3  = 3'd4
    } mem_kind_e;

    typedef enum logic [2:0] {
        W_NONE, W_POWERUP, W_RESET, W_CKE3, W_MODE, W_REFRESH, W_ZQ
    } wait_e;

    typedef struct packed {
        logic cs;
        logic ras;
        logic cas;
        logic we;
    } strobe_t;

    typedef struct packed {
        logic cke;
        logic odt;
        logic reset_n;
    } pins_t;

    typedef struct packed {
        logic                is_pins;
        strobe_t             strb;
        pins_t               pins;
        logic [ADDR_W-1:0]   addr;
        logic [BANK_W-1:0]   bank;
        wait_e               wt;
    } step_t;

    localparam strobe_t STB_PRE = strobe_t'(4'b1101);
    localparam strobe_t STB_MRS = strobe_t'(4'b1111);
    localparam strobe_t STB_REF = strobe_t'(4'b1110);
    localparam strobe_t STB_ZQ  = strobe_t'(4'b1001);

    localparam pins_t PINS_ALL     = pins_t'(3'b111);
    localparam pins_t PINS_UNRESET = pins_t'(3'b011);

    localparam logic [ADDR_W-1:0] ADDR_A10     = ADDR_W'(1024);
    localparam logic [ADDR_W-1:0] ADDR_DLL_RST = ADDR_W'(256);
    localparam logic [ADDR_W-1:0] ADDR_OCD_DEF = ADDR_W'(7 << 7);

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int step_count(mem_kind_e k);
        case (k)
            MEM_SDR:  return 7;
            MEM_DDR2: return 12;
            MEM_DDR3: return 7;
            default:  return 8;
        endcase
    endfunction

    function automatic step_t mk_cmd(strobe_t s, logic [ADDR_W-1:0] a,
                                     logic [BANK_W-1:0] b, wait_e w);
        step_t t;
        t      = '0;
        t.strb = s;
        t.addr = a;
        t.bank = b;
        t.wt   = w;
        return t;
    endfunction

    function automatic step_t mk_pins(pins_t p, wait_e w);
        step_t t;
        t         = '0;
        t.is_pins = 1'b1;
        t.pins    = p;
        t.wt      = w;
        return t;
    endfunction

    // mode word for the pre-DDR3 generations
    function automatic logic [ADDR_W-1:0] legacy_mode(mem_kind_e k, int cl, int nph);
        int bl;
        int w;
        bl = (k == MEM_SDR) ? nph : 2 * nph;
        w  = $clog2(bl) + (cl << 4);
        if (k == MEM_DDR2) w = w + (2 << 9);
        return ADDR_W'(w);
    endfunction

    function automatic logic [3:0] ddr3_cl_code(int cl);
        int c;
        c = (cl <= 11) ? 2 * (cl - 4) : 2 * (cl - 12) + 1;
        return 4'(c);
    endfunction

    function automatic logic [ADDR_W-1:0] ddr3_mr0(int cl);
        logic [ADDR_W-1:0] w;
        logic [3:0]        c;
        w       = '0;
        c       = ddr3_cl_code(cl);
        w[2]    = c[0];
        w[6:4]  = c[3:1];
        w[8]    = 1'b1;
        w[11:9] = 3'b100;
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] ddr3_mr2(int cwl);
        logic [ADDR_W-1:0] w;
        w       = '0;
        w[5:3]  = 3'(cwl - 5);
        w[10:9] = 2'd2;
        return w;
    endfunction

    function automatic step_t legacy_step(mem_kind_e k, int cl, int nph, int i);
        int                extra;
        int                j;
        logic [ADDR_W-1:0] mw;
        extra = (k == MEM_DDR2) ? 3 : ((k == MEM_SDR) ? 0 : 1);
        mw    = legacy_mode(k, cl, nph);
        if (i == 0) return mk_pins(PINS_ALL, W_POWERUP);
        if (i == 1) return mk_cmd(STB_PRE, ADDR_A10, '0, W_NONE);
        if (i < 2 + extra) begin
            if (k == MEM_DDR2) return mk_cmd(STB_MRS, '0, BANK_W'(5 - i), W_NONE);
            return mk_cmd(STB_MRS, '0, (k == MEM_LPDDR) ? BANK_W'(2) : BANK_W'(1), W_NONE);
        end
        j = i - 2 - extra;
        case (j)
            0:       return mk_cmd(STB_MRS, mw | ADDR_DLL_RST, '0, W_MODE);
            1:       return mk_cmd(STB_PRE, ADDR_A10, '0, W_NONE);
            2, 3:    return mk_cmd(STB_REF, '0, '0, W_REFRESH);
            4:       return mk_cmd(STB_MRS, mw, '0, W_MODE);
            5:       return mk_cmd(STB_MRS, ADDR_OCD_DEF, BANK_W'(1), W_NONE);
            default: return mk_cmd(STB_MRS, '0, BANK_W'(1), W_NONE);
        endcase
    endfunction

    function automatic step_t ddr3_step(int cl, int cwl, int i);
        case (i)
            0:       return mk_pins(PINS_UNRESET, W_RESET);
            1:       return mk_pins(PINS_ALL, W_CKE3);
            2:       return mk_cmd(STB_MRS, ddr3_mr2(cwl), BANK_W'(2), W_NONE);
            3:       return mk_cmd(STB_MRS, '0, BANK_W'(3), W_NONE);
            4:       return mk_cmd(STB_MRS, ADDR_W'(6), BANK_W'(1), W_NONE);
            5:       return mk_cmd(STB_MRS, ddr3_mr0(cl), '0, W_MODE);
            default: return mk_cmd(STB_ZQ, ADDR_A10, '0, W_ZQ);
        endcase
    endfunction

    function automatic step_t init_step(mem_kind_e k, int cl, int cwl, int nph, int i);
        if (k == MEM_DDR3) return ddr3_step(cl, cwl, i);
        return legacy_step(k, cl, nph, i);
    endfunction

endpackage

// File: rtl/sdram_init_table.sv
module sdram_init_table
    import sdram_init_pkg::*;
#(
    parameter mem_kind_e KIND    = MEM_DDR3,
    parameter int        CL      = 6,
    parameter int        CWL     = 6,
    parameter int        NPHASES = 4
) (
    input  logic [IDX_W-1:0] idx,
    output step_t            step,
    output logic             last
);
    localparam int N_STEPS = step_count(KIND);

    always_comb begin
        step = init_step(KIND, CL, CWL, NPHASES, int'(idx));
        last = (idx == IDX_W'(N_STEPS - 1));
    end
endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter mem_kind_e MEM_KIND  = MEM_DDR3,
    parameter int        CL        = 6,
    parameter int        CWL       = 6,
    parameter int        NPHASES   = 4,
    parameter int        T_POWERUP = 20000,
    parameter int        T_RESET   = 50000,
    parameter int        T_CKE3    = 10000,
    parameter int        T_MODE    = 200,
    parameter int        T_REFRESH = 4,
    parameter int        T_ZQ      = 200
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cmd_cs,
    output logic              cmd_ras,
    output logic              cmd_cas,
    output logic              cmd_we,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BANK_W-1:0] cmd_bank,
    output logic              pin_cke,
    output logic              pin_odt,
    output logic              pin_reset_n,
    output logic              init_done
);
    localparam int T_MAX = imax(imax(T_POWERUP, T_RESET),
                                imax(imax(T_CKE3, T_MODE), imax(T_REFRESH, T_ZQ)));
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef enum logic [1:0] {PH_BOOT, PH_ISSUE, PH_WAIT, PH_DONE} phase_e;

    phase_e           phase_q;
    logic [IDX_W-1:0] idx_q;
    pins_t            pins_q;
    step_t            cur;
    logic             is_last;
    logic [CNT_W-1:0] wait_len;
    logic             expire;
    logic             issuing;
    strobe_t          strb;
    pins_t            pins;

    sdram_init_table #(
        .KIND(MEM_KIND), .CL(CL), .CWL(CWL), .NPHASES(NPHASES)
    ) u_table (
        .idx (idx_q),
        .step(cur),
        .last(is_last)
    );

    always_comb begin
        case (cur.wt)
            W_POWERUP: wait_len = CNT_W'(T_POWERUP);
            W_RESET:   wait_len = CNT_W'(T_RESET);
            W_CKE3:    wait_len = CNT_W'(T_CKE3);
            W_MODE:    wait_len = CNT_W'(T_MODE);
            W_REFRESH: wait_len = CNT_W'(T_REFRESH);
            W_ZQ:      wait_len = CNT_W'(T_ZQ);
            default:   wait_len = '0;
        endcase
    end

    assign issuing = (phase_q == PH_ISSUE);

    sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (issuing),
        .load_val(wait_len),
        .expire  (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_BOOT;
            idx_q   <= '0;
            pins_q  <= '0;
        end else begin
            case (phase_q)
                PH_BOOT: phase_q <= PH_ISSUE;
                PH_ISSUE: begin
                    if (cur.is_pins) pins_q <= cur.pins;
                    if (wait_len != '0) begin
                        phase_q <= PH_WAIT;
                    end else if (is_last) begin
                        phase_q <= PH_DONE;
                    end else begin
                        idx_q   <= idx_q + IDX_W'(1);
                        phase_q <= PH_ISSUE;
                    end
                end
                PH_WAIT: begin
                    if (expire) begin
                        if (is_last) begin
                            phase_q <= PH_DONE;
                        end else begin
                            idx_q   <= idx_q + IDX_W'(1);
                            phase_q <= PH_ISSUE;
                        end
                    end
                end
                default: phase_q <= PH_DONE;
            endcase
        end
    end

    always_comb begin
        strb = (issuing && !cur.is_pins) ? cur.strb : '0;
        pins = (issuing && cur.is_pins) ? cur.pins : pins_q;
        cmd_cs      = strb.cs;
        cmd_ras     = strb.ras;
        cmd_cas     = strb.cas;
        cmd_we      = strb.we;
        cmd_addr    = (issuing && !cur.is_pins) ? cur.addr : '0;
        cmd_bank    = (issuing && !cur.is_pins) ? cur.bank : '0;
        pin_cke     = pins.cke;
        pin_odt     = pins.odt;
        pin_reset_n = pins.reset_n;
        init_done   = (phase_q == PH_DONE);
    end
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
    import sdram_init_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_cs,
    input logic              cmd_ras,
    input logic              cmd_cas,
    input logic              cmd_we,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              pin_cke,
    input logic              pin_odt,
    input logic              pin_reset_n,
    input logic              init_done
);
    a_r1_strobe_needs_cs: assert property (@(posedge clk) disable iff (rst)
        (cmd_ras || cmd_cas || cmd_we) |-> cmd_cs);

    a_r2_a10_precharge: assert property (@(posedge clk) disable iff (rst)
        (cmd_cs && cmd_ras && !cmd_cas && cmd_we) |-> (cmd_addr[10] && cmd_bank == '0));

    a_r2_a10_zq: assert property (@(posedge clk) disable iff (rst)
        (cmd_cs && !cmd_ras && !cmd_cas && cmd_we) |-> cmd_addr[10]);

    a_r10_pins_quiet_on_cmd: assert property (@(posedge clk) disable iff (rst)
        ({pin_cke, pin_odt, pin_reset_n} != $past({pin_cke, pin_odt, pin_reset_n})) |-> !cmd_cs);

    a_r7_cke_after_reset_release: assert property (@(posedge clk) disable iff (rst)
        pin_cke |-> pin_reset_n);

    a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r11_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (!cmd_cs && $stable({pin_cke, pin_odt, pin_reset_n})));
endmodule

bind sdram_init_seq sdram_init_chk u_chk (.*);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;
    import sdram_init_pkg::*;

    typedef struct {
        bit        is_pins;
        bit [3:0]  strb;
        int        addr;
        int        bank;
        bit [2:0]  pins;
        int        wt;
        string     tag;
    } exp_t;

    localparam int NCFG = 6;
    localparam int K_A  [NCFG] = '{4, 4, 0, 1, 2, 3};
    localparam int CL_A [NCFG] = '{6, 13, 2, 2, 3, 4};
    localparam int CWL_A[NCFG] = '{6, 8, 5, 5, 5, 5};
    localparam int NPH_A[NCFG] = '{4, 4, 2, 2, 1, 2};

    localparam int TP = 20000, TR = 50000, TC3 = 10000, TM = 200, TF = 4, TZ = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   cyc = 0;
    int   mchk = 0;
    int   mfail = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t mk(bit [3:0] s, int a, int b, int w, string t);
        exp_t e;
        e.is_pins = 1'b0; e.strb = s; e.addr = a; e.bank = b; e.pins = 3'b000; e.wt = w; e.tag = t;
        return e;
    endfunction

    function automatic exp_t mkp(bit [2:0] p, int w, string t);
        exp_t e;
        e.is_pins = 1'b1; e.strb = 4'b0000; e.addr = 0; e.bank = 0; e.pins = p; e.wt = w; e.tag = t;
        return e;
    endfunction

    for (genvar gi = 0; gi < NCFG; gi++) begin : g_cfg
        localparam int KI = K_A[gi];
        logic              s_cs, s_ras, s_cas, s_we, s_cke, s_odt, s_rstn, s_done;
        logic [ADDR_W-1:0] s_addr;
        logic [BANK_W-1:0] s_bank;
        exp_t eq[$];
        int   k = 0, last_t = 0, last_w = 0, chk = 0, fail = 0;
        bit   done_seen = 0, rchk = 0;
        bit [2:0] prev_pins = 3'b000;

        sdram_init_seq #(
            .MEM_KIND(mem_kind_e'(3'(KI))), .CL(CL_A[gi]), .CWL(CWL_A[gi]), .NPHASES(NPH_A[gi])
        ) u0 (
            .clk(clk), .rst(rst),
            .cmd_cs(s_cs), .cmd_ras(s_ras), .cmd_cas(s_cas), .cmd_we(s_we),
            .cmd_addr(s_addr), .cmd_bank(s_bank),
            .pin_cke(s_cke), .pin_odt(s_odt), .pin_reset_n(s_rstn),
            .init_done(s_done)
        );

        initial begin
            int cl, bl, mw, code, mr0, mr2;
            cl = CL_A[gi];
            if (KI == 4) begin
                // R8: CAS-latency code split over A2 and A6:A4, DLL reset A8, WR8 = 4 at A11:A9
                code = (cl <= 11) ? 2 * (cl - 4) : 2 * (cl - 12) + 1;
                mr0  = ((code % 2) * 4) + ((code / 2) * 16) + 256 + 4 * 512;
                // R9: CWL-5 at A5:A3, 2 at A10:A9
                mr2  = (CWL_A[gi] - 5) * 8 + 2 * 512;
                eq.push_back(mkp(3'b011, TR, "R7"));
                eq.push_back(mkp(3'b111, TC3, "R7"));
                eq.push_back(mk(4'b1111, mr2, 2, 0, "R9"));
                eq.push_back(mk(4'b1111, 0, 3, 0, "R7"));
                eq.push_back(mk(4'b1111, 6, 1, 0, "R9"));
                eq.push_back(mk(4'b1111, mr0, 0, TM, "R8"));
                eq.push_back(mk(4'b1001, 1024, 0, TZ, "R2"));
            end else begin
                bl = (KI == 0) ? NPH_A[gi] : 2 * NPH_A[gi];
                mw = $clog2(bl) + 16 * cl + ((KI == 3) ? 1024 : 0);   // R4
                eq.push_back(mkp(3'b111, TP, "R3"));
                eq.push_back(mk(4'b1101, 1024, 0, 0, "R2"));
                if (KI == 1) eq.push_back(mk(4'b1111, 0, 1, 0, "R5"));
                if (KI == 2) eq.push_back(mk(4'b1111, 0, 2, 0, "R5"));
                if (KI == 3) begin
                    eq.push_back(mk(4'b1111, 0, 3, 0, "R6"));
                    eq.push_back(mk(4'b1111, 0, 2, 0, "R6"));
                    eq.push_back(mk(4'b1111, 0, 1, 0, "R6"));
                end
                eq.push_back(mk(4'b1111, mw + 256, 0, TM, "R4"));
                eq.push_back(mk(4'b1101, 1024, 0, 0, "R2"));
                eq.push_back(mk(4'b1110, 0, 0, TF, "R3"));
                eq.push_back(mk(4'b1110, 0, 0, TF, "R3"));
                eq.push_back(mk(4'b1111, mw, 0, TM, "R4"));
                if (KI == 3) begin
                    eq.push_back(mk(4'b1111, 896, 1, 0, "R6"));
                    eq.push_back(mk(4'b1111, 0, 1, 0, "R6"));
                end
            end
        end

        always @(negedge clk) begin
            bit [2:0] pn;
            bit [3:0] sn;
            bit       ok;
            exp_t     e;
            pn = {s_cke, s_odt, s_rstn};
            sn = {s_cs, s_ras, s_cas, s_we};
            if (rst) begin
                if (cyc == 3 && !rchk) begin
                    rchk = 1; chk++;
                    if (pn != 0 || sn != 0 || s_done !== 1'b0 || s_addr != 0 || s_bank != 0) begin
                        fail++;
                        $display("FAIL R12 cfg%0d reset outputs act pins=%b strb=%b done=%b exp all 0",
                                 gi, pn, sn, s_done);
                    end
                end
            end else begin
                if (sn != 0 || pn != prev_pins) begin
                    chk++;
                    if (k >= eq.size()) begin
                        fail++;
                        $display("FAIL R11 cfg%0d extra step act strb=%b pins=%b exp none", gi, sn, pn);
                    end else begin
                        e = eq[k];
                        if (e.is_pins) ok = (sn == 0) && (pn == e.pins);
                        else ok = (sn == e.strb) && (pn == prev_pins) &&
                                  (int'(s_addr) == e.addr) && (int'(s_bank) == e.bank);
                        if (!ok) begin
                            fail++;
                            $display("FAIL %s R1 R10 cfg%0d step%0d act strb=%b pins=%b addr=%0h bank=%0d exp strb=%b pins=%b addr=%0h bank=%0d",
                                     e.tag, gi, k, sn, pn, s_addr, s_bank,
                                     e.is_pins ? 4'b0000 : e.strb, e.is_pins ? e.pins : prev_pins, e.addr, e.bank);
                        end
                        if (k > 0) begin
                            chk++;
                            if (cyc - last_t != 1 + last_w) begin
                                fail++;
                                $display("FAIL %s R3 R7 cfg%0d step%0d gap act=%0d exp=%0d",
                                         e.tag, gi, k, cyc - last_t, 1 + last_w);
                            end
                        end
                        last_t = cyc; last_w = e.wt; k++;
                    end
                end
                if (s_done && !done_seen) begin
                    done_seen = 1; chk++;
                    if (k != eq.size() || cyc - last_t != 1 + last_w) begin
                        fail++;
                        $display("FAIL R11 cfg%0d done act steps=%0d gap=%0d exp steps=%0d gap=%0d",
                                 gi, k, cyc - last_t, eq.size(), 1 + last_w);
                    end
                end else if (done_seen && !s_done) begin
                    chk++; fail++;
                    $display("FAIL R11 cfg%0d done dropped act=0 exp=1", gi);
                end
            end
            prev_pins = pn;
        end
    end

    function automatic bit all_done();
        return g_cfg[0].done_seen && g_cfg[1].done_seen && g_cfg[2].done_seen &&
               g_cfg[3].done_seen && g_cfg[4].done_seen && g_cfg[5].done_seen;
    endfunction

    initial begin
        int tchk, tfail;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        while (!all_done() && cyc < 100000) @(posedge clk);
        mchk++;
        if (!all_done()) begin
            mfail++;
            $display("FAIL R11 watchdog act done=0 exp done=1 at cycle %0d", cyc);
        end
        repeat (40) @(posedge clk);
        @(negedge clk);
        // R11: every copy must still report done after the idle stretch
        mchk++;
        if (!(g_cfg[0].s_done && g_cfg[1].s_done && g_cfg[2].s_done &&
              g_cfg[3].s_done && g_cfg[4].s_done && g_cfg[5].s_done)) begin
            mfail++;
            $display("FAIL R11 done not held act=0 exp=1");
        end
        tchk  = mchk + g_cfg[0].chk + g_cfg[1].chk + g_cfg[2].chk +
                g_cfg[3].chk + g_cfg[4].chk + g_cfg[5].chk;
        tfail = mfail + g_cfg[0].fail + g_cfg[1].fail + g_cfg[2].fail +
                g_cfg[3].fail + g_cfg[4].fail + g_cfg[5].fail;
        $display("TB_RESULT checks=%0d failures=%0d", tchk, tfail);
        $finish;
    end
endmodule